// File: doc/BRIEF.md
# Command Ring Header Fetch Front End

This block follows a single circular command ring held in memory. Software programs the ring base address, the ring size and an optional read-pointer writeback address, and then announces new work by writing a new write pointer. Whenever the internal read pointer differs from the write pointer, the block reads the 32-bit header dword at the read pointer through a simple request/acknowledge memory read port. It then hands each header to a downstream decoder over a valid/ready stream, together with its opcode and sub-opcode fields.

Padding packets (opcode 0x00) never leave the block. Their skip count moves the read pointer straight past their payload. When the read pointer catches up with the write pointer, the ring has drained. If the writeback address is nonzero, the block then stores the current read pointer there through a request/acknowledge write port, and returns to idle. The processing (busy) flag is part of the queue state: it rises when work starts and falls once the ring has drained and any writeback has finished.

The control flow is a five-state machine:
- **IDLE**: nothing in flight. It leaves on a write-pointer update that differs from the read pointer (start), on a pointer mismatch that was left pending (resume), or on an update equal to the read pointer while writeback is enabled (flush).
- **FETCH**: the read is outstanding. On acknowledge it takes the padding transition to SCAN, or the header transition to DELIVER.
- **DELIVER**: the header is offered downstream. It takes the accept transition to SCAN.
- **SCAN**: compares the two pointers. It takes the continue transition to FETCH, the drain-with-writeback transition to WBACK, or the drain-quiet transition to IDLE.
- **WBACK**: the writeback is outstanding. It takes the done transition to IDLE.

Top module: `ring_fetch_fe`

## Requirements
- R1: After reset the block is idle: busy, rd_req, wr_req and hdr_valid are low, and both pointers are zero.
- R2: A write-pointer update in IDLE whose value differs from the read pointer raises busy and rd_req in the next cycle, with rd_addr = cfg_base + read pointer.
- R3: Each fetch reads exactly one dword. rd_req and rd_addr hold until rd_ack. A non-padding header is offered on hdr_data with hdr_opcode = bits [7:0] and hdr_subop = bits [15:8], and it is held stable until hdr_ready.
- R4: After each fetched header the read pointer advances by 4 bytes, modulo the ring size.
- R5: A header with opcode 0x00 is padding. It is never offered downstream, and the read pointer advances by 4 plus 4 times the skip count in bits [29:16] (14 bits). A skip count of 0 adds nothing beyond the 4.
- R6: Fetching repeats for as long as the read pointer differs from the write pointer. At most one of rd_req, wr_req and hdr_valid is high at any time.
- R7: On drain with a nonzero cfg_wb_addr, the block writes the read pointer to that address. wr_req, wr_addr and wr_data hold until wr_ack, after which the block goes idle.
- R8: On drain with cfg_wb_addr = 0, no write is issued and the block goes idle.
- R9: busy is high from the cycle the block leaves IDLE until it returns there. While busy is low, no request or header is active.
- R10: The ring size is 2^L bytes, where L is cfg_size_log2 (control bits [6:1]). Values below 6 act as 6 and values above 62 act as 62.
- R11: A write-pointer update in IDLE equal to the read pointer starts no fetch. It performs only the writeback, and only if cfg_wb_addr is nonzero.
- R12: A write-pointer update while busy is taken, and fetching continues to the new pointer without an intermediate writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Ring base byte address |
| cfg_size_log2 | input | 6 | Log2 of ring size in bytes (control bits [6:1]) |
| cfg_wb_addr | input | AW | Read-pointer writeback address, 0 disables |
| wptr_wr | input | 1 | Write-pointer update strobe |
| wptr_val | input | OFS_W | New write pointer, byte offset in the ring |
| rd_req | output | 1 | Header read request |
| rd_addr | output | AW | Header read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Header dword |
| wr_req | output | 1 | Writeback request |
| wr_addr | output | AW | Writeback address |
| wr_data | output | OFS_W | Read pointer being written back |
| wr_ack | input | 1 | Writeback acknowledge |
| hdr_valid | output | 1 | Header offered to decoder |
| hdr_data | output | 32 | Full header dword |
| hdr_opcode | output | 8 | Header opcode, bits [7:0] |
| hdr_subop | output | 8 | Header sub-opcode, bits [15:8] |
| hdr_ready | input | 1 | Decoder accepts header |
| busy | output | 1 | Processing flag |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that read and write requests and the offered header stay stable until taken, that padding opcodes never reach the decoder, that a writeback never targets address zero, that only one activity is live at a time, and that nothing is active while busy is low. Pointer arithmetic can only be shown by the bench scenarios, which compare every read address, header and writeback value in order against a model of the ring. The scenarios cover skip counts and their absence, wrap at a clamped size, a larger ring, equal-pointer updates, disabled writeback and a mid-flight pointer update.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_FETCH   = 3'd1,
        S_DELIVER = 3'd2,
        S_SCAN    = 3'd3,
        S_WBACK   = 3'd4
    } fe_state_t;

    localparam logic [7:0] PAD_OPCODE = 8'h00;
    localparam int         LOG2_MIN   = 6;
    localparam int         LOG2_MAX   = 62;
    localparam int         SKIP_W     = 14;
    localparam int         DW_BYTES   = 4;
endpackage

// File: rtl/ring_hdr_split.sv
module ring_hdr_split
    import ring_fetch_pkg::*;
(
    input  logic [29:0]       hdr_lo,
    output logic [7:0]        opcode,
    output logic [7:0]        subop,
    output logic [SKIP_W-1:0] skip,
    output logic              is_pad
);
    always_comb begin
        opcode = hdr_lo[7:0];
        subop  = hdr_lo[15:8];
        skip   = hdr_lo[29:16];
        is_pad = (hdr_lo[7:0] == PAD_OPCODE);
    end
endmodule

// File: rtl/ring_ptr_step.sv
module ring_ptr_step
    import ring_fetch_pkg::*;
#(
    parameter int OFS_W = 64
) (
    input  logic [OFS_W-1:0]  rptr,
    input  logic [5:0]        size_log2,
    input  logic [SKIP_W-1:0] skip,
    output logic [OFS_W-1:0]  nxt_plain,
    output logic [OFS_W-1:0]  nxt_skip
);
    logic [5:0]       lg_eff;
    logic [OFS_W-1:0] wrap_mask;
    logic [OFS_W-1:0] after_hdr;
    logic [OFS_W-1:0] skip_bytes;

    always_comb begin
        if (int'(size_log2) < LOG2_MIN)      lg_eff = 6'(LOG2_MIN);
        else if (int'(size_log2) > LOG2_MAX) lg_eff = 6'(LOG2_MAX);
        else                                 lg_eff = size_log2;
        // shift of OFS_W or more leaves zero, so the mask becomes all ones
        wrap_mask  = ~({OFS_W{1'b1}} << lg_eff);
        after_hdr  = rptr + OFS_W'(DW_BYTES);
        skip_bytes = OFS_W'({skip, 2'b00});
        nxt_plain  = after_hdr & wrap_mask;
        nxt_skip   = (after_hdr + skip_bytes) & wrap_mask;
    end
endmodule

// File: rtl/ring_fetch_fe.sv
module ring_fetch_fe
    import ring_fetch_pkg::*;
#(
    parameter int AW    = 64,
    parameter int OFS_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cfg_base,
    input  logic [5:0]       cfg_size_log2,
    input  logic [AW-1:0]    cfg_wb_addr,
    input  logic             wptr_wr,
    input  logic [OFS_W-1:0] wptr_val,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_ack,
    input  logic [31:0]      rd_data,
    output logic             wr_req,
    output logic [AW-1:0]    wr_addr,
    output logic [OFS_W-1:0] wr_data,
    input  logic             wr_ack,
    output logic             hdr_valid,
    output logic [31:0]      hdr_data,
    output logic [7:0]       hdr_opcode,
    output logic [7:0]       hdr_subop,
    input  logic             hdr_ready,
    output logic             busy
);
    fe_state_t         state, state_nx;
    logic [OFS_W-1:0]  rptr_q, wptr_q;
    logic [31:0]       hdr_q;
    logic [7:0]        in_opcode, in_subop;
    logic [SKIP_W-1:0] in_skip;
    logic              in_pad;
    logic [OFS_W-1:0]  step_plain, step_skip;
    logic              wb_en;

    assign wb_en = (cfg_wb_addr != '0);

    ring_hdr_split u_split (
        .hdr_lo (rd_data[29:0]),
        .opcode (in_opcode),
        .subop  (in_subop),
        .skip   (in_skip),
        .is_pad (in_pad)
    );

    ring_ptr_step #(.OFS_W(OFS_W)) u_step (
        .rptr      (rptr_q),
        .size_log2 (cfg_size_log2),
        .skip      (in_skip),
        .nxt_plain (step_plain),
        .nxt_skip  (step_skip)
    );

    // state register and queue state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            rptr_q <= '0;
            wptr_q <= '0;
            hdr_q  <= '0;
        end else begin
            state <= state_nx;
            if (wptr_wr) wptr_q <= wptr_val;
            if (state == S_FETCH && rd_ack) begin
                hdr_q  <= rd_data;
                rptr_q <= in_pad ? step_skip : step_plain;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (wptr_wr) begin
                    if (wptr_val != rptr_q) state_nx = S_FETCH;  // start
                    else if (wb_en)         state_nx = S_WBACK;  // flush
                end else if (wptr_q != rptr_q) begin
                    state_nx = S_FETCH;                          // resume
                end
            end
            S_FETCH:   if (rd_ack) state_nx = in_pad ? S_SCAN : S_DELIVER;
            S_DELIVER: if (hdr_ready) state_nx = S_SCAN;         // accept
            S_SCAN: begin
                if (wptr_q != rptr_q) state_nx = S_FETCH;        // continue
                else if (wb_en)       state_nx = S_WBACK;        // drain with writeback
                else                  state_nx = S_IDLE;         // drain quiet
            end
            S_WBACK:   if (wr_ack) state_nx = S_IDLE;            // done
            default:   state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req     = (state == S_FETCH);
        rd_addr    = cfg_base + AW'(rptr_q);
        wr_req     = (state == S_WBACK);
        wr_addr    = cfg_wb_addr;
        wr_data    = rptr_q;
        hdr_valid  = (state == S_DELIVER);
        hdr_data   = hdr_q;
        hdr_opcode = hdr_q[7:0];
        hdr_subop  = hdr_q[15:8];
        busy       = (state != S_IDLE);
    end
endmodule

// File: rtl/ring_fetch_fe_chk.sv
module ring_fetch_fe_chk
    import ring_fetch_pkg::*;
#(
    parameter int AW    = 64,
    parameter int OFS_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             rd_ack,
    input logic [AW-1:0]    rd_addr,
    input logic             wr_req,
    input logic             wr_ack,
    input logic [AW-1:0]    wr_addr,
    input logic [OFS_W-1:0] wr_data,
    input logic             hdr_valid,
    input logic             hdr_ready,
    input logic [31:0]      hdr_data,
    input logic [7:0]       hdr_opcode,
    input logic             busy
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R3
    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data)); // R3
    AST_PAD_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> hdr_opcode != PAD_OPCODE); // R5
    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_req, wr_req, hdr_valid}) <= 1); // R6
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R7
    AST_WB_ADDR_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_addr != '0); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !wr_req && !hdr_valid); // R9
endmodule

bind ring_fetch_fe ring_fetch_fe_chk #(.AW(AW), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .rd_addr    (rd_addr),
    .wr_req     (wr_req),
    .wr_ack     (wr_ack),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .hdr_valid  (hdr_valid),
    .hdr_ready  (hdr_ready),
    .hdr_data   (hdr_data),
    .hdr_opcode (hdr_opcode),
    .busy       (busy)
);

// File: tb/ring_fetch_fe_bench.sv
module ring_fetch_fe_bench;
    localparam logic [63:0] BASE = 64'h1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  cfg_size_log2;
    logic [63:0] cfg_wb_addr;
    logic        wptr_wr;
    logic [63:0] wptr_val;
    logic        rd_req, rd_ack;
    logic [63:0] rd_addr;
    logic [31:0] rd_data;
    logic        wr_req, wr_ack;
    logic [63:0] wr_addr, wr_data;
    logic        hdr_valid, hdr_ready;
    logic [31:0] hdr_data;
    logic [7:0]  hdr_opcode, hdr_subop;
    logic        busy;

    always #10 clk = ~clk;

    ring_fetch_fe u_ring_fetch_fe (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_size_log2(cfg_size_log2),
        .cfg_wb_addr(cfg_wb_addr), .wptr_wr(wptr_wr), .wptr_val(wptr_val),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .hdr_valid(hdr_valid), .hdr_data(hdr_data), .hdr_opcode(hdr_opcode),
        .hdr_subop(hdr_subop), .hdr_ready(hdr_ready), .busy(busy)
    );

    logic [31:0] mem [64];
    int          n_checks = 0;
    int          n_fail = 0;
    int          wr_seen = 0;
    int          cyc = 0;
    bit          stall_mode = 0;
    bit          rd_wait = 0;
    logic [63:0] model_rp = '0;

    // scoreboard: kind 0 = read address, 1 = header, 2 = writeback
    int          q_kind[$];
    logic [63:0] q_a[$];
    logic [63:0] q_d[$];
    string       q_tag[$];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int k, input logic [63:0] a, input logic [63:0] d, input string tag);
        q_kind.push_back(k); q_a.push_back(a); q_d.push_back(d); q_tag.push_back(tag);
    endtask

    task automatic pop_cmp(input int k, input logic [63:0] a, input logic [63:0] d);
        int          ek;
        logic [63:0] ea, ed;
        string       et;
        if (q_kind.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R6 unexpected event kind %0d: got %h expected none", k, a);
            return;
        end
        ek = q_kind.pop_front(); ea = q_a.pop_front(); ed = q_d.pop_front(); et = q_tag.pop_front();
        chk(et, "event kind", 64'(k), 64'(ek));
        chk(et, "event addr", a, ea);
        chk(et, "event data", d, ed);
    endtask

    // driver-side model of the ring, built from the requirements
    task automatic expect_run(input logic [63:0] wp, input logic [5:0] lg_raw,
                              input logic [63:0] wb, input string tag);
        int          lg;
        logic [63:0] mask, rp;
        logic [31:0] h;
        int          guard = 0;
        lg = (lg_raw < 6) ? 6 : ((lg_raw > 62) ? 62 : int'(lg_raw));
        mask = (64'd1 << lg) - 64'd1;
        rp = model_rp;
        while (rp != wp && guard < 200) begin
            guard++;
            push(0, BASE + rp, 64'd0, "R4");
            h  = mem[rp[7:2]];
            rp = (rp + 64'd4) & mask;
            if (h[7:0] == 8'h00) rp = (rp + 64'({h[29:16], 2'b00})) & mask;
            else                 push(1, 64'(h), 64'(h), "R3");
        end
        if (wb != 0) push(2, wb, rp, tag);
        model_rp = rp;
    endtask

    // monitor and memory responder
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (rd_req && !rd_ack) begin
                if (!rd_wait) rd_wait = 1;
                else begin
                    rd_wait = 0;
                    rd_ack  = 1;
                    rd_data = mem[rd_addr[7:2]];
                    pop_cmp(0, rd_addr, 64'd0);
                end
            end else rd_ack = 0;
            if (wr_req && !wr_ack) begin
                wr_ack = 1;
                wr_seen++;
                pop_cmp(2, wr_addr, wr_data);
            end else wr_ack = 0;
            hdr_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
            if (hdr_valid && hdr_ready) begin
                pop_cmp(1, 64'(hdr_data), 64'(hdr_data));
                chk("R3", "opcode field", 64'(hdr_opcode), 64'(hdr_data[7:0]));
                chk("R3", "subop field", 64'(hdr_subop), 64'(hdr_data[15:8]));
                chk("R5", "no pad offered", 64'(hdr_opcode != 8'h00), 64'd1);
            end
        end
    end

    task automatic doorbell(input logic [63:0] wp);
        @(negedge clk); wptr_wr = 1; wptr_val = wp;
        @(negedge clk); wptr_wr = 0;
    endtask

    task automatic wait_drain(input string tag);
        int t = 0;
        do begin @(negedge clk); t++; end
        while ((busy || q_kind.size() != 0) && t < 3000);
        chk(tag, "drained in time", 64'(t < 3000), 64'd1);
        chk(tag, "busy low after drain", 64'(busy), 64'd0);
        chk(tag, "scoreboard empty", 64'(q_kind.size()), 64'd0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog expired: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; wptr_wr = 0; wptr_val = '0; rd_ack = 0; rd_data = '0;
        wr_ack = 0; hdr_ready = 1; cfg_size_log2 = 6'd6; cfg_wb_addr = 64'h2000;
        for (int i = 0; i < 64; i++) mem[i] = {2'b00, 14'(i), 8'(i), 8'(i + 1)};
        mem[3] = {2'b00, 14'd2, 8'h00, 8'h00};   // padding, skip 2 dwords
        mem[6] = {2'b00, 14'd0, 8'h00, 8'h00};   // padding, no skip
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "rd_req", 64'(rd_req), 64'd0);
        chk("R1", "wr_req", 64'(wr_req), 64'd0);
        chk("R1", "hdr_valid", 64'(hdr_valid), 64'd0);
        rst_n = 1;

        // R2: plain headers, start timing
        expect_run(64'd12, 6'd6, 64'h2000, "R7");
        doorbell(64'd12);
        chk("R2", "rd_req next cycle", 64'(rd_req), 64'd1);
        chk("R2", "busy raised", 64'(busy), 64'd1);
        chk("R2", "first address", rd_addr, BASE + 64'd12 - 64'd12);
        wait_drain("R2");

        // R5: padding with and without skip, decoder stalls
        stall_mode = 1;
        expect_run(64'd32, 6'd6, 64'h2000, "R5");
        doorbell(64'd32);
        chk("R9", "busy while working", 64'(busy), 64'd1);
        wait_drain("R5");
        stall_mode = 0;

        // R8: writeback disabled
        cfg_wb_addr = 64'd0; wr_seen = 0;
        expect_run(64'd40, 6'd6, 64'd0, "R8");
        doorbell(64'd40);
        wait_drain("R8");
        chk("R8", "no write issued", 64'(wr_seen), 64'd0);

        // R10 / R4: size field 2 acts as 6, wrap at 64 bytes
        cfg_size_log2 = 6'd2; cfg_wb_addr = 64'h2008;
        expect_run(64'd8, 6'd2, 64'h2008, "R10");
        doorbell(64'd8);
        wait_drain("R10");

        // R11: equal pointer, writeback only, then nothing at all
        cfg_size_log2 = 6'd6; cfg_wb_addr = 64'h2000;
        expect_run(64'd8, 6'd6, 64'h2000, "R11");
        doorbell(64'd8);
        wait_drain("R11");
        cfg_wb_addr = 64'd0; wr_seen = 0;
        doorbell(64'd8);
        chk("R11", "stays idle", 64'(busy), 64'd0);
        chk("R11", "no read", 64'(rd_req), 64'd0);
        repeat (3) @(negedge clk);
        chk("R11", "no write", 64'(wr_seen), 64'd0);

        // R12: pointer update while busy, one writeback at the end
        cfg_wb_addr = 64'h2010; wr_seen = 0;
        expect_run(64'd48, 6'd6, 64'h2010, "R12");
        doorbell(64'd24);
        @(negedge clk);
        doorbell(64'd48);
        wait_drain("R12");
        chk("R12", "single writeback", 64'(wr_seen), 64'd1);

        // R10: 128-byte ring passes 64 without wrapping
        cfg_size_log2 = 6'd7; cfg_wb_addr = 64'h2000;
        expect_run(64'h48, 6'd7, 64'h2000, "R10");
        doorbell(64'h48);
        wait_drain("R10");

        summary();
        $finish;
    end
endmodule